// File: doc/BRIEF.md
# Configurable Edge Event Trigger Channel

This block is one event input channel. Two raw inputs, A and B, can each be inverted. After that, one of them, or their OR, or their AND, is taken as the event source. The source is registered once. Each new sample is compared with the previous one to find rising and falling edges. An edge counts as an event only if its direction is enabled.

Events update a status flag, which has two modes:
- **Sticky capture:** the flag is set by an event and stays set until software clears it.
- **Level rebuild:** every edge moves the flag to a level chosen by that direction's enable.

When pulses are enabled, each event also produces a single-cycle trigger pulse. The pulse goes to one of four output lines, chosen by a 3-bit line select.

All configuration is held in a 32-bit control word written over a one-cycle write strobe. The flag bit can be written by software in the same word and is read back with the rest.

The flag is a two-state machine with states `FLG_CLEAR` and `FLG_SET`. Its transitions are:
- `set_by_edge`: `FLG_CLEAR` to `FLG_SET`, on an event in sticky mode, or on an enabled-direction edge in level mode.
- `clear_by_edge`: `FLG_SET` to `FLG_CLEAR`, in level mode only, on an edge whose direction enable is 0.
- `sw_set` and `sw_clear`: a write of bit 7, applied only when no hardware update happens in the same cycle.
- `hold`: the state is kept in all other cases.

Top module: `evt_trig_chan`

## Requirements
- R1: After reset, every control bit and the flag are 0. `reg_rdata` reads 0 and `trig_out` is 0.
- R2: Control word layout:

  | Bits | Field |
  |------|-------|
  | 0 | pulse enable |
  | 1 | level-rebuild mode |
  | 2 | rising enable |
  | 3 | falling enable |
  | 6:4 | line select |
  | 7 | flag |
  | 9:8 | source select |
  | 10 | invert A |
  | 11 | invert B |

  A write takes effect at the clock edge where `reg_wr` is high. Bits 31:12 always read 0.
- R3: Source select encoding: 0 selects A', 1 selects B', 2 selects A' OR B', 3 selects A' AND B'. Here A' is A XOR invert A, and B' is B XOR invert B.
- R4: A rising edge of the source is an event only when the rising enable is 1. A falling edge is an event only when the falling enable is 1.
- R5: With level-rebuild 0, an event sets the flag. The flag then stays set through any later edges until software writes bit 7 as 0.
- R6: With level-rebuild 1:
  - a rising edge sets the flag to the value of the rising enable;
  - a falling edge sets the flag to the value of the falling enable.
- R7: With pulse enable 1, each event gives a trigger pulse exactly one clock wide. The flag and the pulse update at the second rising clock edge after the source changes. With pulse enable 0 there is no pulse, but the flag still updates.
- R8: Line select values 0 to 3 route the pulse to `trig_out` bit 0 to 3. Values 4 to 7 route it nowhere. At most one output bit is ever high.
- R9: A write sets the flag to bit 7 of the written data. If a hardware flag update happens in the same cycle, the hardware update wins.
- R10: A change of source select or inversion that changes the source level is sampled as an edge. It counts as a real event, giving a flag update and a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_a | input | 1 | Raw event input A |
| in_b | input | 1 | Raw event input B |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data, including the flag |
| trig_out | output | 4 | Trigger pulse lines |

## Verification
A wrong source combination or inversion shows up two cycles after the input change. It appears as a flag that no longer follows the source level in level-rebuild mode, which is why the bench sweeps every select, inversion and input pattern that way.

A lost or spurious edge, or a wrong flag state, appears at `reg_rdata` bit 7 two clock edges after the source change. A misrouted or stretched pulse shows on `trig_out` in the same cycle, and is checked the cycle before, during and after the pulse.

A collision where software wins over hardware leaves the flag cleared, and this is visible one sample later.

// File: rtl/evt_trig_pkg.sv
package evt_trig_pkg;
    // Positions of the control word fields (read back by software)
    localparam int CTRL_W     = 32;
    localparam int BIT_PULSE  = 0;
    localparam int BIT_LVL    = 1;
    localparam int BIT_RISE   = 2;
    localparam int BIT_FALL   = 3;
    localparam int SEL_LO     = 4;
    localparam int SEL_W      = 3;
    localparam int BIT_FLAG   = 7;
    localparam int SRC_LO     = 8;
    localparam int SRC_W      = 2;
    localparam int BIT_INV_A  = 10;
    localparam int BIT_INV_B  = 11;
    localparam int USED_W     = 12;

    typedef enum logic [SRC_W-1:0] {
        SRC_A   = 2'd0,
        SRC_B   = 2'd1,
        SRC_OR  = 2'd2,
        SRC_AND = 2'd3
    } src_mode_e;

    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_SET   = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic             inv_b;
        logic             inv_a;
        src_mode_e        src_sel;
        logic [SEL_W-1:0] line_sel;
        logic             fall_en;
        logic             rise_en;
        logic             lvl_mode;
        logic             pulse_en;
    } chan_cfg_t;
endpackage

// File: rtl/evt_src_cond.sv
module evt_src_cond
    import evt_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_a,
    input  logic      in_b,
    input  logic      inv_a,
    input  logic      inv_b,
    input  src_mode_e src_sel,
    output logic      rise,
    output logic      fall
);
    logic a_c, b_c, src_now;
    logic smp_q, prev_q;

    // Inversion first, then combination
    always_comb begin
        a_c = in_a ^ inv_a;
        b_c = in_b ^ inv_b;
        unique case (src_sel)
            SRC_A:   src_now = a_c;
            SRC_B:   src_now = b_c;
            SRC_OR:  src_now = a_c | b_c;
            SRC_AND: src_now = a_c & b_c;
            default: src_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            smp_q  <= src_now;
            prev_q <= smp_q;
        end
    end

    assign rise = smp_q & ~prev_q;
    assign fall = ~smp_q & prev_q;

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall)); // R4
endmodule

// File: rtl/evt_flag_fsm.sv
module evt_flag_fsm
    import evt_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    input  logic rise_en,
    input  logic fall_en,
    input  logic lvl_mode,
    input  logic sw_wr,
    input  logic sw_val,
    output logic evt,
    output logic flag
);
    flag_state_e state_q, state_d;
    logic        hw_upd;
    logic        hw_val;

    assign evt = (rise & rise_en) | (fall & fall_en);

    // Hardware update request and the value it carries
    always_comb begin
        if (lvl_mode) begin
            hw_upd = rise | fall;
            hw_val = rise ? rise_en : fall_en;
        end else begin
            hw_upd = evt;
            hw_val = 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: begin
                if (hw_upd) begin
                    if (hw_val) state_d = FLG_SET;        // set_by_edge
                end else if (sw_wr && sw_val) begin
                    state_d = FLG_SET;                    // sw_set
                end
            end
            FLG_SET: begin
                if (hw_upd) begin
                    if (!hw_val) state_d = FLG_CLEAR;     // clear_by_edge
                end else if (sw_wr && !sw_val) begin
                    state_d = FLG_CLEAR;                  // sw_clear
                end
            end
            default: state_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    assign flag = (state_q == FLG_SET);

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !lvl_mode && !sw_wr) |=> flag); // R5
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !lvl_mode) |=> flag); // R5
    AST_LVL_RISE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_mode && rise && !rise_en) |=> !flag); // R6
    AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !rise && !fall) |=> (flag == $past(sw_val))); // R9
endmodule

// File: rtl/evt_pulse_route.sv
module evt_pulse_route #(
    parameter int NUM_OUT = 4,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt,
    input  logic               pulse_en,
    input  logic [SEL_W-1:0]   line_sel,
    output logic [NUM_OUT-1:0] trig
);
    logic fire;
    assign fire = evt & pulse_en;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) trig[i] <= 1'b0;
            else        trig[i] <= fire && (line_sel == SEL_W'(i));
        end
    end

    AST_TRIG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trig)); // R8
    AST_TRIG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig) |-> $past(pulse_en && evt)); // R7
    AST_TRIG_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig) |-> ($past(line_sel) < NUM_OUT)); // R8
endmodule

// File: rtl/evt_trig_chan.sv
module evt_trig_chan
    import evt_trig_pkg::*;
#(
    parameter int NUM_OUT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_a,
    input  logic               in_b,
    input  logic               reg_wr,
    input  logic [CTRL_W-1:0]  reg_wdata,
    output logic [CTRL_W-1:0]  reg_rdata,
    output logic [NUM_OUT-1:0] trig_out
);
    chan_cfg_t cfg_q;
    logic      rise, fall, evt, flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (reg_wr) begin
            cfg_q.pulse_en <= reg_wdata[BIT_PULSE];
            cfg_q.lvl_mode <= reg_wdata[BIT_LVL];
            cfg_q.rise_en  <= reg_wdata[BIT_RISE];
            cfg_q.fall_en  <= reg_wdata[BIT_FALL];
            cfg_q.line_sel <= reg_wdata[SEL_LO +: SEL_W];
            cfg_q.src_sel  <= src_mode_e'(reg_wdata[SRC_LO +: SRC_W]);
            cfg_q.inv_a    <= reg_wdata[BIT_INV_A];
            cfg_q.inv_b    <= reg_wdata[BIT_INV_B];
        end
    end

    evt_src_cond u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_a    (in_a),
        .in_b    (in_b),
        .inv_a   (cfg_q.inv_a),
        .inv_b   (cfg_q.inv_b),
        .src_sel (cfg_q.src_sel),
        .rise    (rise),
        .fall    (fall)
    );

    evt_flag_fsm u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .rise_en  (cfg_q.rise_en),
        .fall_en  (cfg_q.fall_en),
        .lvl_mode (cfg_q.lvl_mode),
        .sw_wr    (reg_wr),
        .sw_val   (reg_wdata[BIT_FLAG]),
        .evt      (evt),
        .flag     (flag)
    );

    evt_pulse_route #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .pulse_en (cfg_q.pulse_en),
        .line_sel (cfg_q.line_sel),
        .trig     (trig_out)
    );

    always_comb begin
        reg_rdata                       = '0;
        reg_rdata[BIT_PULSE]            = cfg_q.pulse_en;
        reg_rdata[BIT_LVL]              = cfg_q.lvl_mode;
        reg_rdata[BIT_RISE]             = cfg_q.rise_en;
        reg_rdata[BIT_FALL]             = cfg_q.fall_en;
        reg_rdata[SEL_LO +: SEL_W]      = cfg_q.line_sel;
        reg_rdata[BIT_FLAG]             = flag;
        reg_rdata[SRC_LO +: SRC_W]      = cfg_q.src_sel;
        reg_rdata[BIT_INV_A]            = cfg_q.inv_a;
        reg_rdata[BIT_INV_B]            = cfg_q.inv_b;
    end

    AST_RST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (trig_out == '0)); // R1
endmodule

// File: tb/evt_trig_chan_tb_top.sv
module evt_trig_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_a = 1'b0;
    logic        in_b = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  trig_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    evt_trig_chan dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_a      (in_a),
        .in_b      (in_b),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .trig_out  (trig_out)
    );

    function automatic logic [31:0] mk(input bit pe, input bit lvl, input bit ren,
            input bit fen, input int osel, input bit flg, input int ssel,
            input bit ia, input bit ib);
        logic [31:0] w;
        w = '0;
        w[0] = pe; w[1] = lvl; w[2] = ren; w[3] = fen;
        w[6:4] = 3'(osel); w[7] = flg; w[9:8] = 2'(ssel);
        w[10] = ia; w[11] = ib;
        return w;
    endfunction

    function automatic bit src_f(input int ssel, input bit ia, input bit ib,
            input bit a, input bit b);
        bit ac, bc;
        ac = a ^ ia;
        bc = b ^ ib;
        case (ssel)
            0: return ac;
            1: return bc;
            2: return ac | bc;
            default: return ac & bc;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Pulse must be absent, then present for one cycle, then absent
    task automatic chk_pulse(input logic [3:0] exp, input string req);
        @(negedge clk); chk(32'(trig_out), 32'h0, req);
        @(negedge clk); chk(32'(trig_out), 32'(exp), req);
        @(negedge clk); chk(32'(trig_out), 32'h0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit prev;
        bit exp;
        waitn(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(reg_rdata, 32'h0, "R1 rdata");
        chk(32'(trig_out), 32'h0, "R1 trig");

        // R2 layout and reserved bits
        wr(32'hFFFF_FFFF);
        chk(reg_rdata, 32'h0000_0FFF, "R2 readback");
        waitn(3);
        wr(32'h0);
        waitn(3);
        chk(reg_rdata, 32'h0, "R2 cleared");

        // Sticky mode: rise enabled only, line 1
        wr(mk(1, 0, 1, 0, 1, 0, 0, 0, 0));
        in_a = 1'b1;
        chk_pulse(4'b0010, "R7 rise pulse");
        chk(32'(reg_rdata[7]), 32'h1, "R5 set by rise");
        in_a = 1'b0;
        chk_pulse(4'b0000, "R4 fall disabled");
        chk(32'(reg_rdata[7]), 32'h1, "R5 sticky after fall");
        in_a = 1'b1;
        chk_pulse(4'b0010, "R5 second rise");
        wr(mk(1, 0, 1, 0, 1, 0, 0, 0, 0));
        chk(32'(reg_rdata[7]), 32'h0, "R9 sw clear");
        in_a = 1'b0;
        waitn(3);

        // Falling only
        wr(mk(1, 0, 0, 1, 1, 0, 0, 0, 0));
        in_a = 1'b1;
        chk_pulse(4'b0000, "R4 rise disabled");
        chk(32'(reg_rdata[7]), 32'h0, "R4 no flag on disabled rise");
        in_a = 1'b0;
        chk_pulse(4'b0010, "R4 fall enabled");
        chk(32'(reg_rdata[7]), 32'h1, "R4 flag on fall");

        // Pulse disabled: flag still updates
        wr(mk(0, 0, 1, 1, 1, 0, 0, 0, 0));
        in_a = 1'b1;
        chk_pulse(4'b0000, "R7 no pulse when off");
        chk(32'(reg_rdata[7]), 32'h1, "R7 flag when pulse off");

        // Level rebuild: fall sets, rise clears
        wr(mk(1, 1, 0, 1, 3, 0, 0, 0, 0));
        in_a = 1'b0;
        chk_pulse(4'b1000, "R6 fall event");
        chk(32'(reg_rdata[7]), 32'h1, "R6 set by fall");
        in_a = 1'b1;
        chk_pulse(4'b0000, "R6 rise not event");
        chk(32'(reg_rdata[7]), 32'h0, "R6 cleared by rise");
        wr(mk(1, 1, 1, 1, 3, 0, 0, 0, 0));
        in_a = 1'b0;
        chk_pulse(4'b1000, "R6 both fall");
        chk(32'(reg_rdata[7]), 32'h1, "R6 both set by fall");
        in_a = 1'b1;
        chk_pulse(4'b1000, "R6 both rise");
        chk(32'(reg_rdata[7]), 32'h1, "R6 both set by rise");

        // Routing sweep, both edges enabled
        for (int k = 0; k < 8; k++) begin
            wr(mk(1, 0, 1, 1, k, 0, 0, 0, 0));
            in_a = ~in_a;
            chk_pulse((k < 4) ? 4'(1 << k) : 4'b0000, "R8 route");
        end

        // Collision: hardware set beats software clear
        wr(mk(0, 0, 1, 0, 0, 0, 0, 0, 0));
        in_a = 1'b0;
        waitn(3);
        wr(mk(0, 0, 1, 0, 0, 0, 0, 0, 0));
        chk(32'(reg_rdata[7]), 32'h0, "R9 pre-collision clear");
        in_a = 1'b1;
        @(negedge clk);
        wr(mk(0, 0, 1, 0, 0, 0, 0, 0, 0));
        chk(32'(reg_rdata[7]), 32'h1, "R9 hardware wins");
        wr(mk(0, 0, 1, 0, 0, 0, 0, 0, 0));
        wr(mk(0, 0, 1, 0, 0, 1, 0, 0, 0));
        chk(32'(reg_rdata[7]), 32'h1, "R9 sw set");

        // Config change creates an edge
        in_a = 1'b0;
        in_b = 1'b1;
        wr(mk(1, 0, 1, 0, 2, 0, 0, 0, 0));
        waitn(3);
        wr(mk(1, 0, 1, 0, 2, 0, 0, 0, 0));
        chk(32'(reg_rdata[7]), 32'h0, "R10 pre clear");
        wr(mk(1, 0, 1, 0, 2, 0, 1, 0, 0));
        chk_pulse(4'b0100, "R10 select change pulse");
        chk(32'(reg_rdata[7]), 32'h1, "R10 select change flag");
        wr(mk(1, 0, 1, 0, 2, 0, 0, 0, 0));
        waitn(3);
        wr(mk(1, 0, 1, 0, 2, 0, 0, 1, 0));
        chk_pulse(4'b0100, "R10 inversion change pulse");

        // Source sweep, level rebuild with rising enable: flag follows source
        in_a = 1'b0;
        in_b = 1'b0;
        wr(mk(0, 1, 1, 0, 0, 0, 0, 0, 0));
        waitn(3);
        wr(mk(0, 1, 1, 0, 0, 0, 0, 0, 0));
        waitn(3);
        prev = 1'b0;
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 16; v++) begin
                wr(mk(0, 1, 1, 0, 0, prev, s, v[0], v[1]));
                in_a = v[2];
                in_b = v[3];
                waitn(3);
                exp = src_f(s, v[0], v[1], v[2], v[3]);
                chk(32'(reg_rdata[7]), 32'(exp), "R3 source");
                prev = exp;
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule